// File: doc/BRIEF.md
# Interrupt Controller Initialization Sequencer

This block is the configuration front end of a legacy-style eight-input interrupt controller. Software writes bytes over a simple register bus that has a single address bit. Address 0 selects the command port and address 1 selects the data port. A command-port byte with bit 4 set opens a four-byte setup. The next three data-port bytes are then captured, in order, as the vector base, the slave identity and the mode byte. While the setup is open, the block reports itself busy.

Opening a setup also puts the downstream controller into a known state. The interrupt mask is cleared, the inputs switch to edge triggering, and a one-cycle clear pulse tells the priority, request and in-service logic to reload their defaults. The block exposes those defaults (lowest-priority input 7, slave address 7, special masking off, status reads from the request register). It also provides two acknowledge-time helpers: the full vector formed from the programmed base and the winning input number, and a slave-identity match against the 3-bit cascade code.

The bus has no back-pressure. A write strobe is taken in the cycle it is high, and every stored output updates on the following clock edge. The vector and match outputs are combinational.

Top module: `pic_init_seq`

## Requirements
- R1: A write with `wr_addr`=0 and `wr_data` bit 4 = 1 raises `busy` on the next cycle. `busy` stays high until the third data-port write that follows.
- R2: After that command byte, the next three writes with `wr_addr`=1 are captured in order. `vec_base` takes bits [7:3] of the first, `slave_id` takes the second, and `mode_bits` takes bits [4:0] of the third. `busy` falls on the cycle after the third.
- R3: `mask_bits` resets to 8'hFF. Every opening command byte clears it to 8'h00 on the next cycle.
- R4: An opening command byte makes `init_clr` high for exactly the next cycle and sets `edge_trig` to 1 (reset value 0). `prio_low`=7, `slave_addr`=7, `smm_en`=0 and `rd_irr`=1 hold at all times.
- R5: `vector` equals {`vec_base`, `win_irq`}.
- R6: `vec_own` is 1 only when `ack_valid`=1, `slave_cfg`=1 and `cas_code` equals `slave_id` bits [2:0].
- R7: A third data byte with bit 0 = 0 sets `init_err` on the next cycle. `init_err` stays set until the next opening command byte clears it. A third byte with bit 0 = 1 leaves it clear.
- R8: A data-port write while `busy`=0 loads `mask_bits` with the byte. A data-port write while `busy`=1 leaves `mask_bits` unchanged.
- R9: An opening command byte that arrives mid-setup restarts the capture at the vector-base byte and reapplies all R3, R4 and R7 effects.
- R10: A command-port write with bit 4 = 0 changes no output.
- R11: After reset: `busy`=0, `init_clr`=0, `vec_base`=0, `slave_id`=0, `mode_bits`=0, `init_err`=0, `edge_trig`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 1 | 0 = command port, 1 = data port |
| wr_data | input | 8 | Write byte |
| ack_valid | input | 1 | Acknowledge cycle in progress |
| cas_code | input | 3 | Broadcast cascade code |
| slave_cfg | input | 1 | Controller is configured as a slave |
| win_irq | input | 3 | Number of the winning input |
| busy | output | 1 | Setup in progress |
| init_clr | output | 1 | One-cycle default-reload pulse |
| mask_bits | output | 8 | Interrupt mask |
| edge_trig | output | 1 | Inputs are edge triggered |
| prio_low | output | 3 | Default lowest-priority input |
| slave_addr | output | 3 | Default slave mode address |
| smm_en | output | 1 | Special masking enable (default 0) |
| rd_irr | output | 1 | Status reads select the request register |
| vec_base | output | 5 | Programmed vector base |
| slave_id | output | 8 | Programmed slave identity byte |
| mode_bits | output | 5 | Programmed mode bits |
| init_err | output | 1 | Mode byte lacked the processor-mode bit |
| vector | output | 8 | Acknowledge vector |
| vec_own | output | 1 | This controller supplies the vector |

## Verification
The setup is driven as a clean four-byte run and as a run that carries a different base. The two runs together show that each captured field comes from the correct byte position. Data-port writes are sent both inside and outside a setup, which separates the mask path from the capture path. A restart in the middle of a setup, a mode byte without the processor bit, and a command byte without bit 4 each exercise one of the edge rules. The cascade match is tried with the matching code, with a wrong code, and with slave configuration off.

// File: rtl/pic_init_pkg.sv
package pic_init_pkg;
  localparam int DW = 8;
  localparam int CW = 3;
  localparam int NIRQ = 1 << CW;
  localparam int BW = DW - CW;
  localparam int MW = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BASE = 2'd1,
    ST_SID  = 2'd2,
    ST_MODE = 2'd3
  } seq_st_t;

  localparam logic [CW-1:0] DFLT_PRIO_LOW = '1;
  localparam logic [CW-1:0] DFLT_SL_ADDR  = '1;
  localparam logic          DFLT_SMM      = 1'b0;
  localparam logic          DFLT_RD_IRR   = 1'b1;
endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_init_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          open_hit,
  output logic          cap_base,
  output logic          cap_sid,
  output logic          cap_mode,
  output logic          mask_wr,
  output logic          busy
);
  seq_st_t st_q, st_d;
  logic    data_wr;

  assign open_hit = wr_en && !wr_addr && wr_data[4];
  assign data_wr  = wr_en && wr_addr;
  assign cap_base = data_wr && (st_q == ST_BASE);
  assign cap_sid  = data_wr && (st_q == ST_SID);
  assign cap_mode = data_wr && (st_q == ST_MODE);
  assign mask_wr  = data_wr && (st_q == ST_IDLE);
  assign busy     = (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    if (open_hit) st_d = ST_BASE;
    else if (data_wr) begin
      unique case (st_q)
        ST_BASE: st_d = ST_SID;
        ST_SID:  st_d = ST_MODE;
        ST_MODE: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
endmodule

// File: rtl/pic_init_regs.sv
module pic_init_regs
  import pic_init_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   wr_data,
  input  logic            open_hit,
  input  logic            cap_base,
  input  logic            cap_sid,
  input  logic            cap_mode,
  input  logic            mask_wr,
  output logic            init_clr,
  output logic [NIRQ-1:0] mask_bits,
  output logic            edge_trig,
  output logic [BW-1:0]   vec_base,
  output logic [DW-1:0]   slave_id,
  output logic [MW-1:0]   mode_bits,
  output logic            init_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_clr  <= 1'b0;
      mask_bits <= '1;
      edge_trig <= 1'b0;
      vec_base  <= '0;
      slave_id  <= '0;
      mode_bits <= '0;
      init_err  <= 1'b0;
    end else begin
      init_clr <= open_hit;
      if (open_hit) begin
        mask_bits <= '0;
        edge_trig <= 1'b1;
        init_err  <= 1'b0;
      end else begin
        if (mask_wr)  mask_bits <= wr_data[NIRQ-1:0];
        if (cap_base) vec_base  <= wr_data[DW-1:CW];
        if (cap_sid)  slave_id  <= wr_data;
        if (cap_mode) begin
          mode_bits <= wr_data[MW-1:0];
          init_err  <= ~wr_data[0];
        end
      end
    end
  end
endmodule

// File: rtl/pic_init_cascade.sv
module pic_init_cascade
  import pic_init_pkg::*;
(
  input  logic [BW-1:0] vec_base,
  input  logic [DW-1:0] slave_id,
  input  logic [CW-1:0] win_irq,
  input  logic [CW-1:0] cas_code,
  input  logic          ack_valid,
  input  logic          slave_cfg,
  output logic [DW-1:0] vector,
  output logic          vec_own
);
  logic [CW-1:0] eq_bits;

  for (genvar i = 0; i < CW; i++) begin : g_cmp
    assign eq_bits[i] = ~(cas_code[i] ^ slave_id[i]);
  end

  assign vector  = {vec_base, win_irq};
  assign vec_own = ack_valid && slave_cfg && (&eq_bits);
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_init_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            ack_valid,
  input  logic [CW-1:0]   cas_code,
  input  logic            slave_cfg,
  input  logic [CW-1:0]   win_irq,
  output logic            busy,
  output logic            init_clr,
  output logic [NIRQ-1:0] mask_bits,
  output logic            edge_trig,
  output logic [CW-1:0]   prio_low,
  output logic [CW-1:0]   slave_addr,
  output logic            smm_en,
  output logic            rd_irr,
  output logic [BW-1:0]   vec_base,
  output logic [DW-1:0]   slave_id,
  output logic [MW-1:0]   mode_bits,
  output logic            init_err,
  output logic [DW-1:0]   vector,
  output logic            vec_own
);
  logic open_hit, cap_base, cap_sid, cap_mode, mask_wr;

  pic_init_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .open_hit(open_hit), .cap_base(cap_base),
    .cap_sid(cap_sid), .cap_mode(cap_mode), .mask_wr(mask_wr), .busy(busy)
  );

  pic_init_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .open_hit(open_hit),
    .cap_base(cap_base), .cap_sid(cap_sid), .cap_mode(cap_mode),
    .mask_wr(mask_wr), .init_clr(init_clr), .mask_bits(mask_bits),
    .edge_trig(edge_trig), .vec_base(vec_base), .slave_id(slave_id),
    .mode_bits(mode_bits), .init_err(init_err)
  );

  pic_init_cascade u_cas (
    .vec_base(vec_base), .slave_id(slave_id), .win_irq(win_irq),
    .cas_code(cas_code), .ack_valid(ack_valid), .slave_cfg(slave_cfg),
    .vector(vector), .vec_own(vec_own)
  );

  assign prio_low   = DFLT_PRIO_LOW;
  assign slave_addr = DFLT_SL_ADDR;
  assign smm_en     = DFLT_SMM;
  assign rd_irr     = DFLT_RD_IRR;
endmodule

// File: rtl/pic_init_chk.sv
module pic_init_chk
  import pic_init_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            ack_valid,
  input logic            slave_cfg,
  input logic            busy,
  input logic            init_clr,
  input logic [NIRQ-1:0] mask_bits,
  input logic            edge_trig,
  input logic            init_err,
  input logic            vec_own
);
  logic open_w;
  assign open_w = wr_en && !wr_addr && wr_data[4];

  a_r1_busy_after_open: assert property (@(posedge clk) disable iff (!rst_n)
    open_w |=> busy);
  a_r3_mask_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    open_w |=> (mask_bits == '0));
  a_r4_clr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    open_w |=> (init_clr && edge_trig));
  a_r4_no_stray_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !open_w |=> !init_clr);
  a_r8_mask_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && wr_addr) |=> $stable(mask_bits));
  a_r6_own_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_own |-> (ack_valid && slave_cfg));
  a_r7_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_err && !(busy && wr_en && wr_addr && !wr_data[0])) |=> !init_err);
  a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(wr_en && (wr_addr || wr_data[4]))) |=> (!busy && $stable(mask_bits)));
endmodule

bind pic_init_seq pic_init_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .ack_valid(ack_valid), .slave_cfg(slave_cfg),
  .busy(busy), .init_clr(init_clr), .mask_bits(mask_bits),
  .edge_trig(edge_trig), .init_err(init_err), .vec_own(vec_own)
);

// File: tb/test_pic_init_seq.sv
module test_pic_init_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       ack_valid = 1'b0, slave_cfg = 1'b0;
  logic [2:0] cas_code = 3'd0, win_irq = 3'd0;
  logic       busy, init_clr, edge_trig, smm_en, rd_irr, init_err, vec_own;
  logic [7:0] mask_bits, slave_id, vector;
  logic [2:0] prio_low, slave_addr;
  logic [4:0] vec_base, mode_bits;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pic_init_seq i_pic_init_seq (.*);

  // {addr, data, expected busy, expected vec_base}
  localparam int NV = 8;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 8'h11, 1'b1, 5'd0},
    {1'b1, 8'h40, 1'b1, 5'd8},
    {1'b1, 8'h02, 1'b1, 5'd8},
    {1'b1, 8'h01, 1'b0, 5'd8},
    {1'b0, 8'h10, 1'b1, 5'd8},
    {1'b1, 8'hF8, 1'b1, 5'd31},
    {1'b1, 8'h05, 1'b1, 5'd31},
    {1'b1, 8'h03, 1'b0, 5'd31}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R3 mask reset value, R4 defaults
    chk("R11 busy", busy, 0);
    chk("R11 vec_base", vec_base, 0);
    chk("R11 edge_trig", edge_trig, 0);
    chk("R11 init_err", init_err, 0);
    chk("R3 mask reset", mask_bits, 8'hFF);
    chk("R4 defaults", {prio_low, slave_addr, smm_en, rd_irr}, {3'd7, 3'd7, 1'b0, 1'b1});

    // R1/R2 table walk
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][14], VEC[i][13:6]);
      chk("R1 busy", busy, VEC[i][5]);
      chk("R2 vec_base", vec_base, VEC[i][4:0]);
    end
    chk("R2 slave_id", slave_id, 8'h05);
    chk("R2 mode_bits", mode_bits, 5'h03);
    chk("R7 no err", init_err, 0);

    // R8 idle mask write
    wr(1'b1, 8'hA5);
    chk("R8 idle mask", mask_bits, 8'hA5);
    // R3/R4 open clears mask, pulses clear
    wr(1'b0, 8'h13);
    chk("R3 mask clear", mask_bits, 8'h00);
    chk("R4 init_clr high", init_clr, 1);
    chk("R4 edge_trig", edge_trig, 1);
    @(negedge clk);
    chk("R4 init_clr one cycle", init_clr, 0);
    // R8 busy write goes to capture, not mask
    wr(1'b1, 8'h3C);
    chk("R8 mask held", mask_bits, 8'h00);
    chk("R2 base from busy write", vec_base, 5'd7);
    // R9 restart mid-sequence
    wr(1'b0, 8'h10);
    chk("R9 busy", busy, 1);
    wr(1'b1, 8'h80);
    chk("R9 restart base", vec_base, 5'd16);
    wr(1'b1, 8'h06);
    chk("R9 still busy", busy, 1);
    wr(1'b1, 8'h00);
    chk("R7 err set", init_err, 1);
    chk("R9 done", busy, 0);
    chk("R2 slave_id 2", slave_id, 8'h06);

    // R5/R6
    win_irq = 3'd3; slave_cfg = 1'b1; ack_valid = 1'b1; cas_code = 3'd6;
    #1;
    chk("R5 vector", vector, 8'h83);
    chk("R6 match", vec_own, 1);
    cas_code = 3'd5; #1;
    chk("R6 mismatch", vec_own, 0);
    cas_code = 3'd6; slave_cfg = 1'b0; #1;
    chk("R6 not slave", vec_own, 0);
    ack_valid = 1'b0; slave_cfg = 1'b1; #1;
    chk("R6 no ack", vec_own, 0);

    // R10 command byte without bit 4
    wr(1'b1, 8'h5A);
    wr(1'b0, 8'h08);
    chk("R10 busy", busy, 0);
    chk("R10 mask", mask_bits, 8'h5A);
    chk("R10 err kept", init_err, 1);
    chk("R10 no pulse", init_clr, 0);
    // R7 cleared by open
    wr(1'b0, 8'h10);
    chk("R7 err cleared", init_err, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule